// File: doc/BRIEF.md
# Quad Counter/Timer

The block holds four identical 8-bit down-counters. Each has its own byte-wide write port, selected by `wr_sel`, through which software first sends a configuration byte and then, if that byte requests it, a reload value. A channel either counts active edges on its own trigger input or runs as a timer, ticking once per 16 or once per 256 system clocks. Each time its count reaches zero the channel reloads itself and emits a one-clock zero-count pulse. That pulse can be wired to the trigger input of another channel, so two channels chained together divide a clock by the product of their reload values. For example, a 1,843,200 Hz input divided first by 256 and then by 144 gives a 50 Hz tick.

A channel may also request an interrupt. Every channel has a pending flag. The block presents the vector of the lowest-numbered pending channel, and each acknowledge clears that one flag. All four channels share a single vector base, and the channel number is placed inside the vector. No status register exists, so the vector alone tells which channel interrupted.

Top module: `quad_count_timer`

## Requirements
- R1: A byte whose bit 0 is 1 is a configuration byte, unless the channel is waiting for its reload value. Its bits mean: bit 1 halt, bit 2 reload value follows, bit 3 wait for a trigger edge before starting (timer mode only), bit 4 rising edge (1) or falling edge (0), bit 5 prescale 256 (1) or 16 (0), bit 6 counter mode (1) or timer mode (0), bit 7 interrupt enable. A byte with bit 0 equal to 0, written to channel 0 while channel 0 is not waiting for a reload value, stores bits [7:3] as the vector base. Such a byte written to any other idle channel has no effect.
- R2: A configuration byte with bit 1 set halts the channel. No further zero-count pulse comes from that channel until a new reload value is written.
- R3: In counter mode the channel counts edges of the selected polarity on its trigger input, after a two-flop synchronizer. It pulses once every N edges, where N is the reload value and a reload value of 0 means 256.
- R4: In timer mode the channel pulses once every N×16 clocks, or once every N×256 clocks when bit 5 is set.
- R5: When bit 3 is 0, the channel starts on the clock edge that loads the reload value. When bit 3 is 1 in timer mode, the channel stays idle after loading until the first active trigger edge.
- R6: Each zero-count pulse on `zc_out[i]` lasts exactly one clock. The count reloads at the same time.
- R7: A reload value of 1 in counter mode gives one pulse for each trigger edge.
- R8: A timer channel cascaded into a counter channel divides by the product of the two reload values.
- R9: A zero-count pulse sets the channel's pending flag only when bit 7 is set. `int_req` is high exactly while any flag is pending.
- R10: `int_vec` is {base[7:3], channel[1:0], 0} for the lowest-numbered pending channel. `int_ack` clears that one flag. A new pulse in the same cycle sets the flag again.
- R11: After reset all channels are halted with interrupts disabled, `zc_out` is 0 and `int_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one byte |
| wr_sel | input | 2 | Channel addressed by the write |
| wr_data | input | 8 | Configuration byte, reload value or vector base |
| trig_in | input | 4 | Per-channel trigger inputs (asynchronous) |
| int_ack | input | 1 | Acknowledge of the presented vector |
| zc_out | output | 4 | Per-channel zero-count pulses |
| int_req | output | 1 | Interrupt request |
| int_vec | output | 8 | Vector of the highest-priority pending channel |

## Verification
Counter mode is driven with slow trigger pulses of both polarities and with a reload value of 1, which tests one pulse per edge. A reload value of 0 with 255 and then 256 edges separates the "0 means 256" rule from an off-by-one error. Timer mode runs with both prescalers, free-running and trigger-gated, then with the channel halted and with a timer chained into a counter. These runs separate prescale, gating, halt and cascade errors. Simultaneous interrupts on two channels, together with an ignored byte on a third, test the priority order, the vector layout and the clearing on acknowledge. Throughout, a behavioural model is compared with every output on every clock.

// File: rtl/qct_pkg.sv
package qct_pkg;
  localparam int BYTE_W = 8;

  // bit positions within a configuration byte
  localparam int CW_FLAG = 0;
  localparam int CW_HALT = 1;
  localparam int CW_TC   = 2;
  localparam int CW_GATE = 3;
  localparam int CW_RISE = 4;
  localparam int CW_PRE  = 5;
  localparam int CW_CNT  = 6;
  localparam int CW_IRQ  = 7;

  typedef struct packed {
    logic irq_en;
    logic cnt_mode;
    logic pre_long;
    logic rise_edge;
    logic gated;
  } qct_ctrl_t;

  function automatic qct_ctrl_t qct_decode(input logic [BYTE_W-1:0] b);
    qct_ctrl_t c;
    c.irq_en    = b[CW_IRQ];
    c.cnt_mode  = b[CW_CNT];
    c.pre_long  = b[CW_PRE];
    c.rise_edge = b[CW_RISE];
    c.gated     = b[CW_GATE];
    return c;
  endfunction
endpackage

// File: rtl/qct_sync_edge.sv
module qct_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sh_q, sh_d;
  logic              prev_q;
  logic              cur;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], din};
    cur  = sh_q[STAGES-1];
    rise = cur & ~prev_q;
    fall = ~cur & prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      prev_q <= cur;
    end
  end
endmodule

// File: rtl/qct_channel.sv
module qct_channel
  import qct_pkg::*;
#(
  parameter int PRE_LO = 16,
  parameter int PRE_HI = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              edge_rise,
  input  logic              edge_fall,
  output logic              zc,
  output logic              zc_irq_set,
  output logic              tc_wait
);
  localparam int PW = $clog2(PRE_HI);

  qct_ctrl_t         ctrl_q, ctrl_d;
  logic              expect_q, expect_d;
  logic              run_q, run_d;
  logic              armed_q, armed_d;
  logic [BYTE_W-1:0] tc_q, tc_d;
  logic [BYTE_W-1:0] cnt_q, cnt_d;
  logic [PW-1:0]     pre_q, pre_d;
  logic              zc_q, zc_d;
  logic              trig_edge, tick;
  logic [PW-1:0]     pre_lim;

  always_comb begin
    trig_edge = ctrl_q.rise_edge ? edge_rise : edge_fall;
    pre_lim   = ctrl_q.pre_long ? PW'(PRE_HI - 1) : PW'(PRE_LO - 1);
    ctrl_d    = ctrl_q;
    expect_d  = expect_q;
    run_d     = run_q;
    armed_d   = armed_q;
    tc_d      = tc_q;
    cnt_d     = cnt_q;
    pre_d     = pre_q;
    zc_d      = 1'b0;
    tick      = 1'b0;
    if (wr_hit) begin
      if (expect_q) begin
        // reload value: restart countdown from it
        tc_d     = wr_data;
        cnt_d    = wr_data;
        expect_d = 1'b0;
        pre_d    = '0;
        if (ctrl_q.cnt_mode || !ctrl_q.gated) begin
          run_d   = 1'b1;
          armed_d = 1'b0;
        end else begin
          run_d   = 1'b0;
          armed_d = 1'b1;
        end
      end else if (wr_data[CW_FLAG]) begin
        ctrl_d   = qct_decode(wr_data);
        expect_d = wr_data[CW_TC];
        if (wr_data[CW_HALT]) begin
          run_d   = 1'b0;
          armed_d = 1'b0;
        end
      end
    end else if (run_q) begin
      if (ctrl_q.cnt_mode) begin
        tick = trig_edge;
      end else if (pre_q == pre_lim) begin
        pre_d = '0;
        tick  = 1'b1;
      end else begin
        pre_d = pre_q + PW'(1);
      end
      if (tick) begin
        if (cnt_q == BYTE_W'(1)) begin
          cnt_d = tc_q;
          zc_d  = 1'b1;
        end else begin
          cnt_d = cnt_q - BYTE_W'(1);
        end
      end
    end else if (armed_q && trig_edge) begin
      run_d   = 1'b1;
      armed_d = 1'b0;
      pre_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      expect_q <= 1'b0;
      run_q    <= 1'b0;
      armed_q  <= 1'b0;
      tc_q     <= '0;
      cnt_q    <= '0;
      pre_q    <= '0;
      zc_q     <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_d;
      expect_q <= expect_d;
      run_q    <= run_d;
      armed_q  <= armed_d;
      tc_q     <= tc_d;
      cnt_q    <= cnt_d;
      pre_q    <= pre_d;
      zc_q     <= zc_d;
    end
  end

  assign zc         = zc_q;
  assign zc_irq_set = zc_d & ctrl_q.irq_en;
  assign tc_wait    = expect_q;
endmodule

// File: rtl/qct_irq.sv
module qct_irq #(
  parameter int NCH = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCH-1:0]         set_req,
  input  logic                   ack,
  input  logic                   base_we,
  input  logic [7-$clog2(NCH):0] base_in,
  output logic                   req,
  output logic [7:0]             vec
);
  localparam int IDX_W  = $clog2(NCH);
  localparam int BASE_W = 8 - 1 - IDX_W;

  logic [NCH-1:0]    pend_q, pend_d, first_oh;
  logic [BASE_W-1:0] base_q, base_d;
  logic [IDX_W-1:0]  idx;

  always_comb begin
    idx = '0;
    for (int k = NCH - 1; k >= 0; k--) begin
      if (pend_q[k]) idx = IDX_W'(k);
    end
    first_oh = pend_q & (~pend_q + NCH'(1));
    pend_d   = (ack ? (pend_q & ~first_oh) : pend_q) | set_req;
    base_d   = base_we ? base_in : base_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      base_q <= '0;
    end else begin
      pend_q <= pend_d;
      base_q <= base_d;
    end
  end

  assign req = |pend_q;
  assign vec = {base_q, idx, 1'b0};
endmodule

// File: rtl/quad_count_timer.sv
module quad_count_timer
  import qct_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int PRE_LO      = 16,
  parameter int PRE_HI      = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(NCH)-1:0]   wr_sel,
  input  logic [7:0]               wr_data,
  input  logic [NCH-1:0]           trig_in,
  input  logic                     int_ack,
  output logic [NCH-1:0]           zc_out,
  output logic                     int_req,
  output logic [7:0]               int_vec
);
  localparam int IDX_W = $clog2(NCH);

  logic [1:0]     rs_q;
  logic           rst_core_n;
  logic [NCH-1:0] e_rise, e_fall, irq_set, tc_wait;
  logic           base_we;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    qct_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_core_n),
      .din  (trig_in[g]),
      .rise (e_rise[g]),
      .fall (e_fall[g])
    );
    qct_channel #(.PRE_LO(PRE_LO), .PRE_HI(PRE_HI)) u_chan (
      .clk       (clk),
      .rst_n     (rst_core_n),
      .wr_hit    (wr_en && (wr_sel == IDX_W'(g))),
      .wr_data   (wr_data),
      .edge_rise (e_rise[g]),
      .edge_fall (e_fall[g]),
      .zc        (zc_out[g]),
      .zc_irq_set(irq_set[g]),
      .tc_wait   (tc_wait[g])
    );
  end

  assign base_we = wr_en && (wr_sel == '0) && !wr_data[CW_FLAG] && !tc_wait[wr_sel];

  qct_irq #(.NCH(NCH)) u_irq (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .set_req(irq_set),
    .ack    (int_ack),
    .base_we(base_we),
    .base_in(wr_data[7:IDX_W+1]),
    .req    (int_req),
    .vec    (int_vec)
  );
endmodule

// File: rtl/quad_count_timer_chk.sv
module quad_count_timer_chk #(
  parameter int NCH = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_en,
  input logic [$clog2(NCH)-1:0] wr_sel,
  input logic [7:0]             wr_data,
  input logic                   int_ack,
  input logic [NCH-1:0]         zc_out,
  input logic                   int_req
);
  for (genvar g = 0; g < NCH; g++) begin : g_pulse
    assert_zc_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      zc_out[g] |=> !zc_out[g]);
  end

  assert_halt_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[0] && wr_data[1]) |=> !zc_out[$past(wr_sel)]);

  assert_req_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_req) |-> (zc_out != '0));

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req && !int_ack) |=> int_req);
endmodule

bind quad_count_timer quad_count_timer_chk #(.NCH(NCH)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .wr_en  (wr_en),
  .wr_sel (wr_sel),
  .wr_data(wr_data),
  .int_ack(int_ack),
  .zc_out (zc_out),
  .int_req(int_req)
);

// File: tb/quad_count_timer_bench.sv
module quad_count_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [3:0] trig_drv = 4'd0;
  logic       casc = 1'b0;
  logic       int_ack = 1'b0;
  logic [3:0] trig_in;
  logic [3:0] zc_out;
  logic       int_req;
  logic [7:0] int_vec;

  int checks = 0;
  int errors = 0;
  int zcnt [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign trig_in = {casc ? zc_out[2] : trig_drv[3], trig_drv[2:0]};

  quad_count_timer u_quad_count_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .trig_in(trig_in), .int_ack(int_ack), .zc_out(zc_out), .int_req(int_req),
    .int_vec(int_vec)
  );

  // behavioural reference model
  bit m_irq[4], m_cnt[4], m_p256[4], m_rise[4], m_gate[4], m_exp[4], m_run[4], m_arm[4];
  bit m_s1[4], m_s2[4], m_pv[4];
  int m_count[4], m_tc[4], m_pcnt[4];
  bit [3:0] m_zc, m_pend;
  int m_base;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        m_irq[i] = 0; m_cnt[i] = 0; m_p256[i] = 0; m_rise[i] = 0; m_gate[i] = 0;
        m_exp[i] = 0; m_run[i] = 0; m_arm[i] = 0; m_s1[i] = 0; m_s2[i] = 0; m_pv[i] = 0;
        m_count[i] = 0; m_tc[i] = 0; m_pcnt[i] = 0;
      end
      m_zc = 0; m_pend = 0; m_base = 0;
    end else begin
      bit [3:0] nzc;
      bit [3:0] setv;
      nzc = 0; setv = 0;
      for (int i = 0; i < 4; i++) begin
        bit e;
        bit tk;
        e  = m_rise[i] ? (m_s2[i] && !m_pv[i]) : (!m_s2[i] && m_pv[i]);
        tk = 0;
        if (wr_en && wr_sel == i) begin
          if (m_exp[i]) begin
            m_tc[i] = wr_data; m_count[i] = wr_data; m_exp[i] = 0; m_pcnt[i] = 0;
            if (m_cnt[i] || !m_gate[i]) begin m_run[i] = 1; m_arm[i] = 0; end
            else begin m_run[i] = 0; m_arm[i] = 1; end
          end else if (wr_data[0]) begin
            m_irq[i] = wr_data[7]; m_cnt[i] = wr_data[6]; m_p256[i] = wr_data[5];
            m_rise[i] = wr_data[4]; m_gate[i] = wr_data[3]; m_exp[i] = wr_data[2];
            if (wr_data[1]) begin m_run[i] = 0; m_arm[i] = 0; end
          end else if (i == 0) begin
            m_base = wr_data >> 3;
          end
        end else if (m_run[i]) begin
          if (m_cnt[i]) tk = e;
          else begin
            int lim;
            lim = m_p256[i] ? 255 : 15;
            if (m_pcnt[i] == lim) begin m_pcnt[i] = 0; tk = 1; end
            else m_pcnt[i]++;
          end
          if (tk) begin
            if (m_count[i] == 1) begin m_count[i] = m_tc[i]; nzc[i] = 1; end
            else m_count[i] = (m_count[i] + 255) % 256;
          end
        end else if (m_arm[i] && e) begin
          m_run[i] = 1; m_arm[i] = 0; m_pcnt[i] = 0;
        end
        if (nzc[i] && m_irq[i]) setv[i] = 1;
        m_pv[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = trig_in[i];
      end
      if (int_ack) begin
        for (int k = 0; k < 4; k++) begin
          if (m_pend[k]) begin m_pend[k] = 0; break; end
        end
      end
      m_pend = m_pend | setv;
      m_zc = nzc;
    end
  end

  function automatic int exp_vec();
    for (int k = 0; k < 4; k++) if (m_pend[k]) return (m_base << 3) | (k << 1);
    return m_base << 3;
  endfunction

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (zc_out !== m_zc) begin
        errors++;
        $display("FAIL R6 zc_out actual %b expected %b at %0t", zc_out, m_zc, $time);
      end
      checks++;
      if (int_req !== (m_pend != 0)) begin
        errors++;
        $display("FAIL R9 int_req actual %b expected %b at %0t", int_req, m_pend != 0, $time);
      end
      if (int_req) begin
        checks++;
        if (int_vec !== 8'(exp_vec())) begin
          errors++;
          $display("FAIL R10 int_vec actual %h expected %h at %0t", int_vec, 8'(exp_vec()), $time);
        end
      end
      for (int i = 0; i < 4; i++) if (zc_out[i]) zcnt[i]++;
    end
  end

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); wr_sel = s; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    #1;
  endtask

  task automatic pulse(input logic [3:0] m);
    @(negedge clk); trig_drv = trig_drv | m;
    waitc(3);
    @(negedge clk); trig_drv = trig_drv & ~m;
    waitc(3);
  endtask

  task automatic ack_once();
    @(negedge clk); int_ack = 1'b1;
    @(negedge clk); int_ack = 1'b0;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int s;
    for (int i = 0; i < 4; i++) zcnt[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    waitc(4);
    // R11 reset state
    chk("R11 zc_out", zc_out, 0);
    chk("R11 int_req", int_req, 0);

    // R3 R7 counter mode, rising edges, reload 1
    wr(2'd0, 8'h55); wr(2'd0, 8'h01);
    s = zcnt[0];
    for (int k = 0; k < 5; k++) pulse(4'b0001);
    waitc(10);
    chk("R7 one pulse per edge", zcnt[0] - s, 5);

    // R3 falling edges, reload 0 means 256
    wr(2'd1, 8'h45); wr(2'd1, 8'h00);
    s = zcnt[1];
    for (int k = 0; k < 255; k++) pulse(4'b0010);
    waitc(10);
    chk("R3 no pulse after 255 edges", zcnt[1] - s, 0);
    pulse(4'b0010);
    waitc(10);
    chk("R3 pulse after 256 edges", zcnt[1] - s, 1);

    // R4 timer mode, prescale 16, reload 4
    wr(2'd2, 8'h05); wr(2'd2, 8'h04);
    s = zcnt[2];
    waitc(640);
    chk("R4 prescale 16", zcnt[2] - s, 10);
    // R4 prescale 256, reload 2
    wr(2'd2, 8'h25); wr(2'd2, 8'h02);
    s = zcnt[2];
    waitc(1100);
    chk("R4 prescale 256", zcnt[2] - s, 2);

    // R2 halt
    wr(2'd2, 8'h03);
    s = zcnt[2];
    waitc(600);
    chk("R2 halted channel silent", zcnt[2] - s, 0);

    // R5 gated start
    wr(2'd2, 8'h1D); wr(2'd2, 8'h01);
    s = zcnt[2];
    waitc(100);
    chk("R5 gated waits for edge", zcnt[2] - s, 0);
    pulse(4'b0100);
    waitc(150);
    chk("R5 gated runs after edge", (zcnt[2] - s) >= 8, 1);
    wr(2'd2, 8'h03);

    // R8 cascade timer(4 x 16) into counter(3)
    casc = 1'b1;
    wr(2'd3, 8'h55); wr(2'd3, 8'h03);
    wr(2'd2, 8'h05); wr(2'd2, 8'h04);
    s = zcnt[3];
    waitc(800);
    chk("R8 cascade divides by product", zcnt[3] - s, 4);
    wr(2'd2, 8'h03); wr(2'd3, 8'h03);
    casc = 1'b0;
    waitc(10);

    // R1 R9 R10 interrupts
    wr(2'd0, 8'hA0);
    wr(2'd2, 8'h48);
    wr(2'd0, 8'h55); wr(2'd0, 8'h01);
    wr(2'd1, 8'hD5); wr(2'd1, 8'h01);
    wr(2'd3, 8'hD5); wr(2'd3, 8'h01);
    pulse(4'b0001);
    waitc(4);
    chk("R9 no request with irq disabled", int_req, 0);
    pulse(4'b1010);
    waitc(2);
    chk("R9 request raised", int_req, 1);
    chk("R1 R10 vector of channel 1", int_vec, 8'hA2);
    ack_once();
    chk("R10 vector of channel 3 after ack", int_vec, 8'hA6);
    chk("R10 request still high", int_req, 1);
    ack_once();
    chk("R10 request cleared", int_req, 0);

    waitc(5);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule